// File: doc/BRIEF.md
# Input-Port Virtual Channel Allocator

This block sits at one input link of a network router. Flits arrive through a valid/acknowledge handshake. Each flit carries a data word and two framing bits: one marks the header flit of a packet, the other marks its last flit. When a header arrives, the block picks a virtual channel (VC) that is both unlocked and enabled by the power manager, and locks it. The header and every later flit of that packet go into that VC's FIFO, up to and including the tail. Packets may have any length.

The output side drains each VC FIFO through a per-VC read strobe and sees a per-VC read-ready flag and the flit at the FIFO head. A VC's lock is held while any flit of its packet is still buffered. The lock drops on the clock edge at which the tail flit is read out, and only then can that VC take a new packet. The enable mask only affects which VC a new header may choose. A packet already open keeps flowing into its VC even if that VC is later disabled.

Top module: `ivc_alloc`

## Requirements
- R1: Each VC's read port presents a flit of DATA_W+2 bits: data in bits [DATA_W-1:0], the end-of-packet bit at bit DATA_W and the begin-of-packet bit at bit DATA_W+1. VC i occupies bits [i*(DATA_W+2) +: DATA_W+2] of the read bus.
- R2: A header flit with no packet open is acknowledged in the same cycle when some VC is both unlocked and enabled. The lowest-index such VC receives it, and that VC's lock bit is high from the next clock edge.
- R3: A header flit arriving when no VC is both unlocked and enabled is not acknowledged. Nothing is stored and no lock changes.
- R4: After a header without end-of-packet, every flit through the end-of-packet flit is written in arrival order into the VC chosen for that header.
- R5: While a packet is open, a flit is acknowledged only when the chosen VC's FIFO (FIFO_DEPTH flits, default 5) has space. A withheld flit is not lost when resent, and acknowledge is never high without valid.
- R6: A VC's lock stays set while flits of its packet remain, and is low after the edge at which its end-of-packet flit is read out. A read-ready flag is never high on an unlocked VC.
- R7: A flit without the begin-of-packet bit that arrives while no packet is open is acknowledged and discarded: no lock and no read-ready flag changes.
- R8: Read-ready of VC i is high exactly when its FIFO holds a flit. A read strobe on an empty VC has no effect.
- R9: After reset, all locks and read-ready flags are low and no packet is open.
- R10: Clearing a VC's enable bit while its packet is open does not stop the remaining flits of that packet from being accepted into it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Flit present on the link |
| in_data | input | DATA_W | Flit data word |
| in_head | input | 1 | Begin-of-packet framing bit |
| in_tail | input | 1 | End-of-packet framing bit |
| in_ack | output | 1 | Flit taken this cycle |
| vc_enable | input | NUM_VC | VCs the power manager allows for new packets |
| rd_en | input | NUM_VC | Per-VC read strobe from the output side |
| rd_ready | output | NUM_VC | Per-VC FIFO non-empty flag |
| rd_flit | output | NUM_VC*(DATA_W+2) | Per-VC flit at the FIFO head |
| vc_lock | output | NUM_VC | Per-VC lock bit |

## Verification
The bench targets the choice among several candidate VCs when lower ones are locked or disabled. A design with a wrong priority or one that ignores the mask would steer the packet to the wrong FIFO. It fills a FIFO to capacity mid-packet and resends the withheld flits, which exposes an overflow or a lost or duplicated flit in the drained order. It watches the lock across the reads of a multi-flit packet. A release on the first read, or no release at the tail, shows up as an early or stuck lock. Stray body flits, reads of empty VCs, and headers with no candidate are also driven, where a faulty design would lock a VC, raise a ready flag or accept the header.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic {
    LS_IDLE = 1'b0,
    LS_OPEN = 1'b1
  } link_state_e;
endpackage

// File: rtl/ivc_pick.sv
// Lowest-index selector over a candidate vector.
module ivc_pick #(
  parameter int NUM_VC = 4,
  localparam int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic [NUM_VC-1:0] cand,
  output logic              found,
  output logic [VW-1:0]     idx
);
  always_comb begin
    found = |cand;
    idx   = '0;
    for (int i = NUM_VC - 1; i >= 0; i--) begin
      if (cand[i]) idx = VW'(i);
    end
  end
endmodule

// File: rtl/ivc_fifo.sv
// One VC buffer: circular store with an occupancy counter.
module ivc_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign do_wr     = wr & ~full;
  assign do_rd     = rd & not_empty;
  assign rdata     = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (do_wr || do_rd) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/ivc_alloc.sv
module ivc_alloc #(
  parameter int DATA_W     = 32,
  parameter int NUM_VC     = 4,
  parameter int FIFO_DEPTH = 5,
  localparam int FW = DATA_W + 2,
  localparam int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 in_head,
  input  logic                 in_tail,
  output logic                 in_ack,
  input  logic [NUM_VC-1:0]    vc_enable,
  input  logic [NUM_VC-1:0]    rd_en,
  output logic [NUM_VC-1:0]    rd_ready,
  output logic [NUM_VC*FW-1:0] rd_flit,
  output logic [NUM_VC-1:0]    vc_lock
);
  import ivc_pkg::*;

  link_state_e       st_q, st_d;
  logic [VW-1:0]     cur_q, cur_d, wr_sel, pick_idx;
  logic [NUM_VC-1:0] lock_q, lock_d, lock_set, lock_clr, fifo_full;
  logic              pick_found, hdr_take, do_write;
  logic [FW-1:0]     wflit;

  assign wflit   = {in_head, in_tail, in_data};
  assign vc_lock = lock_q;

  ivc_pick #(.NUM_VC(NUM_VC)) u_pick (
    .cand  (~lock_q & vc_enable),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // Link control: acknowledge, write steering, next state
  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    wr_sel   = cur_q;
    in_ack   = 1'b0;
    do_write = 1'b0;
    hdr_take = 1'b0;
    if (st_q == LS_IDLE) begin
      if (in_valid && in_head) begin
        if (pick_found) begin
          in_ack   = 1'b1;
          do_write = 1'b1;
          hdr_take = 1'b1;
          wr_sel   = pick_idx;
          cur_d    = pick_idx;
          if (!in_tail) st_d = LS_OPEN;
        end
      end else if (in_valid) begin
        in_ack = 1'b1;  // stray flit outside a packet: discarded
      end
    end else begin
      if (in_valid && !fifo_full[cur_q]) begin
        in_ack   = 1'b1;
        do_write = 1'b1;
        if (in_tail) st_d = LS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LS_IDLE;
      cur_q <= '0;
    end else begin
      if (in_valid && in_ack) st_q <= st_d;
      if (hdr_take) cur_q <= cur_d;
    end
  end

  // Per-VC buffers and lock bookkeeping
  for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
    logic          wr_g;
    logic [FW-1:0] head_g;

    assign wr_g = do_write && (wr_sel == VW'(g));

    ivc_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_g),
      .wdata     (wflit),
      .rd        (rd_en[g]),
      .rdata     (head_g),
      .not_empty (rd_ready[g]),
      .full      (fifo_full[g])
    );

    assign rd_flit[g*FW +: FW] = head_g;
    assign lock_set[g] = hdr_take && (wr_sel == VW'(g));
    assign lock_clr[g] = rd_en[g] & rd_ready[g] & head_g[DATA_W];
  end

  always_comb begin
    lock_d = (lock_q | lock_set) & ~lock_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else if (|(lock_set | lock_clr)) lock_q <= lock_d;
  end
endmodule

// File: rtl/ivc_alloc_chk.sv
module ivc_alloc_chk #(
  parameter int NUM_VC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_head,
  input logic              in_ack,
  input logic [NUM_VC-1:0] vc_enable,
  input logic [NUM_VC-1:0] vc_lock,
  input logic [NUM_VC-1:0] rd_ready
);
  // A lock appears only after an acknowledged header
  assert_lock_after_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(vc_lock & ~$past(vc_lock))) |-> $past(in_valid && in_ack && in_head));

  // At most one VC is newly locked per cycle
  assert_single_new_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc_lock & ~$past(vc_lock)));

  // Newly locked VC was enabled when chosen
  assert_lock_on_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((vc_lock & ~$past(vc_lock) & ~$past(vc_enable)) == '0));

  // Buffered flits only ever sit in a locked VC
  assert_ready_needs_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_ready & ~vc_lock) == '0));

  // No acknowledge without a flit offered
  assert_ack_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> in_valid);
endmodule

bind ivc_alloc ivc_alloc_chk #(.NUM_VC(NUM_VC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_head   (in_head),
  .in_ack    (in_ack),
  .vc_enable (vc_enable),
  .vc_lock   (vc_lock),
  .rd_ready  (rd_ready)
);

// File: tb/ivc_alloc_tb.sv
module ivc_alloc_tb;
  localparam int DW = 32;
  localparam int NV = 4;
  localparam int FW = DW + 2;

  logic           clk, rst_n, in_valid, in_head, in_tail, in_ack;
  logic [DW-1:0]  in_data;
  logic [NV-1:0]  vc_enable, rd_en, rd_ready, vc_lock;
  logic [NV*FW-1:0] rd_flit;
  int errors = 0, checks = 0;
  bit done = 0;

  ivc_alloc #(.DATA_W(DW), .NUM_VC(NV), .FIFO_DEPTH(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_head(in_head), .in_tail(in_tail), .in_ack(in_ack),
    .vc_enable(vc_enable), .rd_en(rd_en), .rd_ready(rd_ready),
    .rd_flit(rd_flit), .vc_lock(vc_lock)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Offer one flit for one cycle; report whether it was taken
  task automatic send(input logic h, input logic t, input logic [DW-1:0] d, output logic ack);
    in_valid = 1; in_head = h; in_tail = t; in_data = d;
    #1 ack = in_ack;
    @(posedge clk); @(negedge clk);
    in_valid = 0; in_head = 0; in_tail = 0;
  endtask

  task automatic rd(input int vc, output logic [FW-1:0] f);
    f = rd_flit[vc*FW +: FW];
    rd_en[vc] = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = '0;
  endtask

  function automatic logic [FW-1:0] fl(input logic h, input logic t, input logic [DW-1:0] d);
    return {h, t, d};
  endfunction

  task automatic t_reset();
    check(vc_lock, 0, "R9 lock after reset");
    check(rd_ready, 0, "R9 ready after reset");
    check(in_ack, 0, "R9 ack idle");
  endtask

  task automatic t_basic();
    logic a; logic [FW-1:0] f;
    vc_enable = 4'b1111;
    send(1, 0, 32'hA1, a); check(a, 1, "R2 header ack");
    check(vc_lock, 4'b0001, "R2 lock VC0");
    send(0, 0, 32'hA2, a); check(a, 1, "R4 body ack");
    send(0, 1, 32'hA3, a); check(a, 1, "R4 tail ack");
    check(rd_ready, 4'b0001, "R8 ready VC0");
    rd(0, f); check(f, fl(1, 0, 32'hA1), "R1 header flit layout");
    check(vc_lock, 4'b0001, "R6 lock held after header read");
    rd(0, f); check(f, fl(0, 0, 32'hA2), "R4 body order");
    check(vc_lock, 4'b0001, "R6 lock held after body read");
    rd(0, f); check(f, fl(0, 1, 32'hA3), "R1 tail bit position");
    check(vc_lock, 4'b0000, "R6 lock released on tail read");
    check(rd_ready, 4'b0000, "R8 empty after drain");
  endtask

  task automatic t_lowest();
    logic a; logic [FW-1:0] f;
    send(1, 0, 32'hB1, a); send(0, 1, 32'hB2, a);
    send(1, 0, 32'hC1, a); check(a, 1, "R2 second header ack");
    send(0, 1, 32'hC2, a);
    check(vc_lock, 4'b0011, "R2 lowest free VC1");
    check(rd_ready, 4'b0011, "R8 ready VC0 VC1");
    rd(1, f); check(f, fl(1, 0, 32'hC1), "R4 packet C in VC1");
    rd(1, f); check(f, fl(0, 1, 32'hC2), "R4 packet C tail in VC1");
    check(vc_lock, 4'b0001, "R6 only VC1 released");
    rd(0, f); check(f, fl(1, 0, 32'hB1), "R4 packet B in VC0");
    rd(0, f);
    check(vc_lock, 4'b0000, "R6 all released");
  endtask

  task automatic t_mask();
    logic a; logic [FW-1:0] f;
    vc_enable = 4'b1100;
    send(1, 0, 32'hD1, a); check(a, 1, "R2 header with mask");
    check(vc_lock, 4'b0100, "R2 masked pick VC2");
    vc_enable = 4'b1000;
    send(0, 1, 32'hD2, a); check(a, 1, "R10 tail after disable");
    rd(2, f); rd(2, f); check(f, fl(0, 1, 32'hD2), "R10 tail stored in VC2");
    check(vc_lock, 4'b0000, "R6 VC2 released");
    vc_enable = 4'b1111;
  endtask

  task automatic t_nofree();
    logic a; logic [FW-1:0] f;
    vc_enable = 4'b0011;
    send(1, 1, 32'hE0, a); send(1, 1, 32'hE1, a);
    check(vc_lock, 4'b0011, "R2 single-flit packets lock");
    send(1, 0, 32'hE2, a); check(a, 0, "R3 no candidate no ack");
    check(vc_lock, 4'b0011, "R3 locks unchanged");
    check(rd_ready, 4'b0011, "R3 nothing stored");
    rd(0, f); check(vc_lock, 4'b0010, "R6 single-flit release");
    send(1, 1, 32'hE3, a); check(a, 1, "R2 header after release");
    check(vc_lock, 4'b0011, "R2 VC0 reused");
    rd(0, f); check(f, fl(1, 1, 32'hE3), "R1 single flit both bits");
    rd(1, f);
    vc_enable = 4'b1111;
  endtask

  task automatic t_full();
    logic a; logic [FW-1:0] f;
    send(1, 0, 32'hF0, a);
    for (int k = 1; k < 5; k++) begin
      send(0, 0, 32'hF0 + k, a); check(a, 1, "R5 fill ack");
    end
    send(0, 0, 32'hF5, a); check(a, 0, "R5 full stall");
    rd(0, f); check(f, fl(1, 0, 32'hF0), "R5 first out");
    send(0, 0, 32'hF5, a); check(a, 1, "R5 resend accepted");
    send(0, 1, 32'hF6, a); check(a, 0, "R5 full stall on tail");
    rd(0, f);
    send(0, 1, 32'hF6, a); check(a, 1, "R5 tail resend accepted");
    for (int k = 2; k < 7; k++) begin
      rd(0, f); check(f, fl(0, (k == 6), 32'hF0 + k), "R5 no loss order");
    end
    check(vc_lock, 4'b0000, "R6 release after full drain");
  endtask

  task automatic t_stray();
    logic a;
    send(0, 0, 32'h55, a); check(a, 1, "R7 stray acked");
    check(vc_lock, 4'b0000, "R7 stray no lock");
    check(rd_ready, 4'b0000, "R7 stray not stored");
    rd_en = 4'b1111; @(posedge clk); @(negedge clk); rd_en = '0;
    check(rd_ready, 4'b0000, "R8 read on empty ignored");
    send(1, 1, 32'h66, a);
    check(rd_ready, 4'b0001, "R8 ready after empty read");
    rd_en = 4'b0001; @(posedge clk); @(negedge clk); rd_en = '0;
    check(vc_lock, 4'b0000, "R6 release single");
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_head = 0; in_tail = 0; in_data = '0;
    vc_enable = '1; rd_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_basic(); t_lowest(); t_mask(); t_nofree(); t_full(); t_stray();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule